// File: doc/BRIEF.md
# GPIO Line Bank with Edge Interrupts

This block controls thirty-two general-purpose lines from a small 32-bit register bus. Software chooses, for each line, whether it drives or listens, whether a driven line is push-pull or open-drain, and what level it drives. Incoming levels pass through a two-flop synchronizer. They can be read back through a per-line input enable and are watched for edges. Each edge sets a sticky event bit, and a mask selects which events raise the single combined interrupt output.

Every per-line register uses a mirrored bit order: line n sits at register bit 31-n. The pin ports themselves are indexed by line number. Software reads the event register to find pending lines and writes ones to clear them. If an edge arrives in the same cycle as its clear, the edge wins.

The bus side is a two-state machine. BUS_IDLE accepts a request whenever `bus_sel` is high and moves to BUS_RESP. In BUS_RESP, `bus_ready` is high and `bus_rdata` is valid; the machine always returns to BUS_IDLE on the next edge. The transitions are IDLE_TO_RESP (request accepted) and RESP_TO_IDLE (unconditional).

Top module: `gpio_irq_bank`

## Requirements
- R1: Word addresses select the registers as follows: 0 direction, 1 open-drain, 2 data, 3 event, 4 mask, 5 sense, 6 input-enable. A request accepted while idle gets `bus_ready` high for exactly one cycle, on the cycle after acceptance. A write takes effect at the acceptance edge. Word address 7 reads as 0, and writes to it change nothing.
- R2: After reset every register reads 0, `pin_oe` is 0 and `irq` is 0.
- R3: Line n (port bit n of `pin_in`, `pin_out` and `pin_oe`) corresponds to bit 31-n of every register.
- R4: A direction bit of 1 makes a line an output, driving the data bit with its enable set. A direction bit of 0 makes it an input, with enable 0 and output 0.
- R5: For an output line whose open-drain bit is 1, `pin_out` is 0 and `pin_oe` is the inverse of the data bit. The open-drain bit has no effect on input lines.
- R6: A data-register read returns the written value for output lines. For input lines it returns the synchronized pin value ANDed with the input-enable bit.
- R7: A pin change made before clock edge k is visible to a read accepted at edge k+2, but not to one accepted at edge k+1. It sets its event bit at edge k+2.
- R8: A sense bit of 1 records only falling edges, and a sense bit of 0 records both edges. Detection works on the synchronized pin regardless of direction, input-enable or mask.
- R9: Writing the event register clears each bit written as 1 and keeps bits written as 0. An edge landing on the same cycle as its clear leaves the bit set.
- R10: `irq` is high exactly when some event bit and its mask bit are both 1. Events are still recorded while masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Request valid |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| bus_ready | output | 1 | One-cycle response strobe |
| pin_in | input | 32 | Line input levels, bit n = line n |
| pin_out | output | 32 | Line output levels, bit n = line n |
| pin_oe | output | 32 | Line output enables, bit n = line n |
| irq | output | 1 | Combined masked event interrupt |

## Verification
Two functions can meet in one cycle: an edge detected on a line, and a software clear of that same event bit. The bench provokes this by changing a pin on the falling clock edge two cycles before it issues a write of all ones to the event register, so the clear is accepted on the very edge at which the event is recorded. The bit must read back as set while all other pending bits are gone. A second attempt, one cycle later, must leave the bit cleared.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int LINES  = 32;
    localparam int AW     = 3;
    localparam int SYNC_N = 2;

    typedef logic [LINES-1:0] word_t;

    localparam logic [AW-1:0] RG_DIR    = 3'd0;
    localparam logic [AW-1:0] RG_ODRAIN = 3'd1;
    localparam logic [AW-1:0] RG_DATA   = 3'd2;
    localparam logic [AW-1:0] RG_EVENT  = 3'd3;
    localparam logic [AW-1:0] RG_MASK   = 3'd4;
    localparam logic [AW-1:0] RG_SENSE  = 3'd5;
    localparam logic [AW-1:0] RG_INEN   = 3'd6;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

    // Converts between line order and register order (bit i <-> bit LINES-1-i).
    function automatic word_t flip_lines(input word_t v);
        word_t r;
        for (int i = 0; i < LINES; i++) begin
            r[i] = v[LINES-1-i];
        end
        return r;
    endfunction
endpackage

// File: rtl/gpio_sync_chain.sv
module gpio_sync_chain #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0][W-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < DEPTH; s++) begin
                stg[s] <= stg[s-1];
            end
        end
    end

    assign q      = stg[STAGES-1];
    assign q_prev = stg[STAGES];
endmodule

// File: rtl/gpio_event_bank.sv
module gpio_event_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] fall_only,
    input  logic         clr_en,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] evt
);
    logic [W-1:0] hit;
    logic [W-1:0] keep;

    generate
        for (genvar b = 0; b < W; b++) begin : g_bit
            logic falling;
            logic rising;
            assign falling = prev[b] & ~cur[b];
            assign rising  = cur[b] & ~prev[b];
            assign hit[b]  = falling | (rising & ~fall_only[b]);
            assign keep[b] = ~(clr_en & clr_bits[b]);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt <= '0;
        end else begin
            evt <= (evt & keep) | hit;
        end
    end
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
    parameter int W = 32
) (
    input  logic [W-1:0] dir,
    input  logic [W-1:0] odrain,
    input  logic [W-1:0] level,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe
);
    generate
        for (genvar n = 0; n < W; n++) begin : g_line
            localparam int B = W - 1 - n;
            always_comb begin
                unique case ({dir[B], odrain[B]})
                    2'b10: begin
                        pin_out[n] = level[B];
                        pin_oe[n]  = 1'b1;
                    end
                    2'b11: begin
                        pin_out[n] = 1'b0;
                        pin_oe[n]  = ~level[B];
                    end
                    default: begin
                        pin_out[n] = 1'b0;
                        pin_oe[n]  = 1'b0;
                    end
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_bus_fsm.sv
module gpio_bus_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    output logic accept,
    output logic ready
);
    import gpio_bank_pkg::*;

    bus_state_e state_q;
    bus_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (sel) state_d = BUS_RESP;
            BUS_RESP: state_d = BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        accept = 1'b0;
        ready  = 1'b0;
        unique case (state_q)
            BUS_IDLE: accept = sel;
            BUS_RESP: ready  = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int W  = gpio_bank_pkg::LINES,
    parameter int AW = gpio_bank_pkg::AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    output logic          bus_ready,
    input  logic [W-1:0]  pin_in,
    output logic [W-1:0]  pin_out,
    output logic [W-1:0]  pin_oe,
    output logic          irq
);
    logic [W-1:0] dir_q, od_q, dat_q, ibe_q, mask_q, sense_q, evt_q;
    logic [W-1:0] sync_line, prev_line;
    logic [W-1:0] sync_reg, prev_reg, data_view, rd_mux;
    logic         accept, wr_acc, evt_clr_en;

    gpio_bus_fsm i_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (bus_sel),
        .accept (accept),
        .ready  (bus_ready)
    );

    gpio_sync_chain #(.W(W), .STAGES(SYNC_N)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d      (pin_in),
        .q      (sync_line),
        .q_prev (prev_line)
    );

    assign sync_reg = flip_lines(sync_line);
    assign prev_reg = flip_lines(prev_line);

    assign wr_acc     = accept & bus_we;
    assign evt_clr_en = wr_acc & (bus_addr == RG_EVENT);

    gpio_event_bank #(.W(W)) i_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur       (sync_reg),
        .prev      (prev_reg),
        .fall_only (sense_q),
        .clr_en    (evt_clr_en),
        .clr_bits  (bus_wdata),
        .evt       (evt_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q   <= '0;
            od_q    <= '0;
            dat_q   <= '0;
            ibe_q   <= '0;
            mask_q  <= '0;
            sense_q <= '0;
        end else if (wr_acc) begin
            case (bus_addr)
                RG_DIR:    dir_q   <= bus_wdata;
                RG_ODRAIN: od_q    <= bus_wdata;
                RG_DATA:   dat_q   <= bus_wdata;
                RG_MASK:   mask_q  <= bus_wdata;
                RG_SENSE:  sense_q <= bus_wdata;
                RG_INEN:   ibe_q   <= bus_wdata;
                default: ;
            endcase
        end
    end

    assign data_view = ((sync_reg & ibe_q) & ~dir_q) | (dat_q & dir_q);

    always_comb begin
        case (bus_addr)
            RG_DIR:    rd_mux = dir_q;
            RG_ODRAIN: rd_mux = od_q;
            RG_DATA:   rd_mux = data_view;
            RG_EVENT:  rd_mux = evt_q;
            RG_MASK:   rd_mux = mask_q;
            RG_SENSE:  rd_mux = sense_q;
            RG_INEN:   rd_mux = ibe_q;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (accept) bus_rdata <= rd_mux;
    end

    gpio_pad_drive #(.W(W)) i_pad (
        .dir     (dir_q),
        .odrain  (od_q),
        .level   (dat_q),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    assign irq = |(evt_q & mask_q);
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
    import gpio_bank_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bus_ready,
    input logic        irq,
    input logic [31:0] pin_oe,
    input logic [31:0] pin_out,
    input logic [31:0] dir_q,
    input logic [31:0] od_q,
    input logic [31:0] mask_q,
    input logic [31:0] evt_q,
    input logic        evt_clr_en
);
    p_ready_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready);

    p_input_no_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_q == '0) |-> (pin_oe == '0));

    p_od_low_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out & flip_lines(od_q)) == '0));

    p_evt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_clr_en |=> ((evt_q & $past(evt_q)) == $past(evt_q)));

    p_irq_needs_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);

    p_irq_needs_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_q == '0) |-> !irq);
endmodule

bind gpio_irq_bank gpio_irq_bank_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_ready  (bus_ready),
    .irq        (irq),
    .pin_oe     (pin_oe),
    .pin_out    (pin_out),
    .dir_q      (dir_q),
    .od_q       (od_q),
    .mask_q     (mask_q),
    .evt_q      (evt_q),
    .evt_clr_en (evt_clr_en)
);

// File: tb/test_gpio_irq_bank.sv
module test_gpio_irq_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, pin_in = '0;
    logic [31:0] bus_rdata, pin_out, pin_oe;
    logic        bus_ready, irq;

    int total = 0, fails = 0;
    logic [31:0] m_dir = 0, m_od = 0, m_dat = 0, m_evt = 0, m_mask = 0, m_sense = 0, m_ibe = 0;
    logic [31:0] pins = 0;

    always #5 clk = ~clk;

    gpio_irq_bank i_gpio_irq_bank (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq(irq)
    );

    function automatic logic [31:0] flip(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = v[31-i];
        return r;
    endfunction

    function automatic logic [31:0] hits(input logic [31:0] o, input logic [31:0] n,
                                         input logic [31:0] s);
        return (o & ~n) | (n & ~o & ~s);
    endfunction

    function automatic logic [31:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0: return m_dir;
            3'd1: return m_od;
            3'd2: return ((flip(pins) & m_ibe) & ~m_dir) | (m_dat & m_dir);
            3'd3: return m_evt;
            3'd4: return m_mask;
            3'd5: return m_sense;
            3'd6: return m_ibe;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
        chk("R1 ready after write", {31'd0, bus_ready}, 32'd1);
        case (a)
            3'd0: m_dir = d;
            3'd1: m_od = d;
            3'd2: m_dat = d;
            3'd3: m_evt = m_evt & ~d;
            3'd4: m_mask = d;
            3'd5: m_sense = d;
            3'd6: m_ibe = d;
            default: ;
        endcase
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        @(negedge clk);
        bus_sel = 0;
        chk("R1 ready after read", {31'd0, bus_ready}, 32'd1);
        d = bus_rdata;
    endtask

    task automatic rd_chk(input logic [2:0] a, input string req);
        logic [31:0] got;
        bus_read(a, got);
        chk(req, got, exp_read(a));
    endtask

    task automatic set_pins(input logic [31:0] v);
        @(negedge clk);
        m_evt = m_evt | hits(flip(pins), flip(v), m_sense);
        pins = v; pin_in = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic pin_chk(input string req);
        chk({req, " pin_oe"}, pin_oe, flip(m_dir & (~m_od | ~m_dat)));
        chk({req, " pin_out"}, pin_out, flip(m_dir & ~m_od & m_dat));
        chk({req, " irq"}, {31'd0, irq}, {31'd0, |(m_evt & m_mask)});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [31:0] got;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R2 reset state
        for (int a = 0; a < 8; a++) rd_chk(a[2:0], "R2 reset read");
        pin_chk("R2");

        // R3 mirror: line 0 is register bit 31
        bus_write(3'd0, 32'h8000_0000);
        bus_write(3'd2, 32'h8000_0000);
        chk("R3 line0 oe", pin_oe, 32'h0000_0001);
        chk("R3 line0 out", pin_out, 32'h0000_0001);

        // R4 push-pull mix
        bus_write(3'd0, 32'hFFFF_0000);
        bus_write(3'd2, 32'hA5C3_5A5A);
        pin_chk("R4");

        // R5 open-drain, including on input lines
        bus_write(3'd1, 32'hF0F0_F0F0);
        pin_chk("R5");
        rd_chk(3'd1, "R5 odrain read");

        // R6 input enable gating
        bus_write(3'd0, 32'h0000_0000);
        set_pins(32'hFFFF_FFFF);
        rd_chk(3'd2, "R6 inputs gated off");
        bus_write(3'd6, 32'h0000_FFFF);
        rd_chk(3'd2, "R6 inputs partly enabled");
        bus_write(3'd0, 32'h00FF_00FF);
        rd_chk(3'd2, "R6 mixed data view");

        // R1 unmapped address
        bus_write(3'd7, 32'hDEAD_BEEF);
        rd_chk(3'd7, "R1 unmapped read");
        rd_chk(3'd0, "R1 unmapped write ignored");

        // R8 falling-only vs both-edge
        bus_write(3'd3, 32'hFFFF_FFFF);
        bus_write(3'd5, 32'hFFFF_FFFF);
        set_pins(32'hFFFF_FFF7);
        set_pins(32'hFFFF_FFFF);
        rd_chk(3'd3, "R8 falling only");
        bus_write(3'd5, 32'h0);
        set_pins(32'hFFFF_FFFB);
        set_pins(32'hFFFF_FFFF);
        rd_chk(3'd3, "R8 both edges");

        // R10 masked capture then unmask
        chk("R10 masked irq", {31'd0, irq}, 32'd0);
        bus_write(3'd4, 32'hFFFF_FFFF);
        chk("R10 unmasked irq", {31'd0, irq}, 32'd1);

        // R9 zero write keeps events
        bus_write(3'd3, 32'h0);
        rd_chk(3'd3, "R9 zero write keeps");
        bus_write(3'd3, 32'hFFFF_FFFF);
        rd_chk(3'd3, "R9 all ones clears");

        // R7 data and event latency
        @(negedge clk);
        pin_in = 32'hFFFF_FFFE;
        bus_read(3'd2, got);
        chk("R7 read at k+1 sees old", got, exp_read(3'd2));
        pins = 32'hFFFF_FFFE;
        m_evt = m_evt | 32'h8000_0000;
        rd_chk(3'd2, "R7 read later sees new");
        bus_write(3'd3, 32'hFFFF_FFFF);
        @(negedge clk);
        pin_in = 32'hFFFF_FFFF;
        @(negedge clk);
        @(negedge clk);
        chk("R7 no event at k+1", {31'd0, irq}, 32'd0);
        @(negedge clk);
        chk("R7 event at k+2", {31'd0, irq}, 32'd1);
        pins = 32'hFFFF_FFFF;
        m_evt = m_evt | 32'h8000_0000;

        // R9 clear colliding with a new edge
        set_pins(32'hFFFF_FFDF);
        @(negedge clk);
        pin_in = 32'hFFFF_FDDF;
        @(negedge clk);
        bus_write(3'd3, 32'hFFFF_FFFF);
        pins = 32'hFFFF_FDDF;
        m_evt = 32'h0040_0000;
        repeat (3) @(negedge clk);
        rd_chk(3'd3, "R9 edge wins over clear");
        @(negedge clk);
        pin_in = 32'hFFFF_FFDF;
        @(negedge clk);
        @(negedge clk);
        bus_write(3'd3, 32'hFFFF_FFFF);
        pins = 32'hFFFF_FFDF;
        m_evt = 32'h0;
        repeat (3) @(negedge clk);
        rd_chk(3'd3, "R9 clear one cycle late wins");

        // Random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            op = $urandom % 4;
            case (op)
                0: bus_write(3'($urandom % 8), $urandom);
                1: set_pins($urandom);
                2: rd_chk(3'($urandom % 8), "R6/R8/R9 random read");
                default: pin_chk("R4/R5/R10 random");
            endcase
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule